// File: doc/BRIEF.md
# Debug Event Qualification Unit

This unit sits next to a processor pipeline. Each cycle the core reports its debug event strobes: a taken branch, a trap match, a return instruction and its kind, a completed instruction, an interrupt being taken and its class, and an unconditional request arriving from the test port. Each event type has its own suppression rule. The rule depends on that event's enable bit, the machine-state debug-enable bit and the debug mode bits (internal, external, wait). An event that passes its rule sets a sticky bit in a status register.

Software clears status bits by writing ones to them. The unit raises a registered debug interrupt request when internal debug mode is on, debug-enable is set and at least one status bit is set. Three kinds of rule apply. Some events are never gated. Some are masked only when internal mode is on, debug-enable is clear and neither external nor wait mode is on. Critical-class interrupts are masked whenever internal mode is on without external or wait mode, whatever the debug-enable bit.

Top module: `dbgq_unit`

## Requirements
- R1: A taken-branch strobe with its enable (en[0]) set sets status[0]. It is suppressed when mode_int=1, msr_de=0, mode_ext=0 and mode_wait=0.
- R2: A trap strobe with en[1] set sets status[1] in every mode and for either value of msr_de.
- R3: A return strobe with ret_kind=2'b00 (normal) and en[2] set sets status[2] in every mode and for either value of msr_de.
- R4: A return strobe whose ret_kind is not 2'b00 (01 critical, 10 machine-check; 11 is treated the same way) follows the R1 suppression rule for status[2].
- R5: An instruction-complete strobe with en[3] set sets status[3] under the R1 suppression rule.
- R6: An interrupt strobe with irq_critical=0 and en[4] set sets status[4] in every mode and for either value of msr_de.
- R7: An interrupt strobe with irq_critical=1 and en[4] set is suppressed whenever mode_int=1 and both mode_ext and mode_wait are 0, for either value of msr_de.
- R8: An unconditional request strobe sets status[5] always. It has no enable bit and no gating.
- R9: dbg_irq is 1 exactly when, at the previous clock edge, mode_int=1, msr_de=1 and the updated status was nonzero. With mode_int=0 it stays 0 even when mode_ext or mode_wait is set.
- R10: When clr_wr=1, each status bit whose clr_mask bit is 1 is cleared at the next edge. A clear has no effect on a bit set by an event in the same cycle, because the new event wins.
- R11: Events that qualify in the same cycle all set their status bits at the same edge. The updated status and dbg_irq appear one clock edge after the strobe.
- R12: While rst_n is low at a clock edge, status becomes 0 and dbg_irq becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_branch | input | 1 | Taken branch whose conditions are met |
| ev_trap | input | 1 | Trap instruction matched its conditions |
| ev_ret | input | 1 | Return-from-interrupt executed |
| ret_kind | input | 2 | Return kind: 00 normal, 01 critical, 10 machine-check |
| ev_done | input | 1 | Instruction completed |
| ev_irq | input | 1 | Interrupt taken |
| irq_critical | input | 1 | Taken interrupt belongs to the critical class |
| ev_ude | input | 1 | Unconditional request from the test port |
| en | input | 5 | Per-event enables: 0 branch, 1 trap, 2 return, 3 complete, 4 interrupt |
| msr_de | input | 1 | Machine-state debug-enable bit |
| mode_int | input | 1 | Internal debug mode on |
| mode_ext | input | 1 | External debug mode on |
| mode_wait | input | 1 | Debug wait mode on |
| clr_wr | input | 1 | Write strobe for clearing status bits |
| clr_mask | input | 6 | Write-one-to-clear mask, same bit order as status |
| status | output | 6 | Sticky recorded events: 0 branch, 1 trap, 2 return, 3 complete, 4 interrupt, 5 unconditional |
| dbg_irq | output | 1 | Registered debug interrupt request |

## Verification
The assertions assume that mode and enable inputs are stable over the cycle in which a strobe is sampled. They also assume that ret_kind and irq_critical are only meaningful while their strobe is high. The suppression property for critical interrupts is stated only for cycles whose status bit is already clear and where no clear is pending. The bench keeps to these assumptions by driving every input a short time after a rising edge and holding it for one whole cycle. It also sets modes before pulsing a strobe and clears status between scenarios, so each gating case starts from a known zero.

// File: rtl/dbgq_pkg.sv
// Shared constants for the debug event qualification unit.
// Assumes event bit positions are identical in the enable and status vectors.
package dbgq_pkg;
    localparam int EV_N      = 6;          // number of status bits
    localparam int EN_N      = 5;          // number of enable bits (unconditional has none)
    localparam int B_BRANCH  = 0;
    localparam int B_TRAP    = 1;
    localparam int B_RET     = 2;
    localparam int B_DONE    = 3;
    localparam int B_IRQ     = 4;
    localparam int B_UDE     = 5;

    typedef enum logic [1:0] {
        RK_NORMAL   = 2'b00,
        RK_CRITICAL = 2'b01,
        RK_MCHECK   = 2'b10
    } ret_kind_e;
endpackage

// File: rtl/dbgq_gate.sv
// Combinational qualification of one cycle's debug event strobes.
// Assumes strobes, enables and mode bits are all valid in the same cycle.
module dbgq_gate
    import dbgq_pkg::*;
(
    input  logic            ev_branch,
    input  logic            ev_trap,
    input  logic            ev_ret,
    input  logic [1:0]      ret_kind,
    input  logic            ev_done,
    input  logic            ev_irq,
    input  logic            irq_critical,
    input  logic            ev_ude,
    input  logic [EN_N-1:0] en,
    input  logic            msr_de,
    input  logic            mode_int,
    input  logic            mode_ext,
    input  logic            mode_wait,
    output logic [EV_N-1:0] qual
);
    logic other_mode;
    logic mask_std;
    logic mask_crit;
    logic ret_crit;

    // Derive the two suppression conditions shared by the event rules.
    always_comb begin
        other_mode = mode_ext | mode_wait;
        mask_crit  = mode_int & ~other_mode;
        mask_std   = mask_crit & ~msr_de;
        ret_crit   = (ret_kind != RK_NORMAL);
    end

    // Apply each event's own enable and suppression rule.
    always_comb begin
        qual           = '0;
        qual[B_BRANCH] = ev_branch & en[B_BRANCH] & ~mask_std;
        qual[B_TRAP]   = ev_trap   & en[B_TRAP];
        qual[B_RET]    = ev_ret    & en[B_RET] & (~ret_crit | ~mask_std);
        qual[B_DONE]   = ev_done   & en[B_DONE] & ~mask_std;
        qual[B_IRQ]    = ev_irq    & en[B_IRQ] & (~irq_critical | ~mask_crit);
        qual[B_UDE]    = ev_ude;
    end
endmodule

// File: rtl/dbgq_status.sv
// Sticky status register: qualified events set bits, a write of ones clears them.
// Assumes a set and a clear of the same bit in one cycle resolve to set.
module dbgq_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Next value of one bit: new event wins over a clear.
        always_comb begin
            stat_d[i] = set_vec[i] | (stat_q[i] & ~(clr_wr & clr_mask[i]));
        end

        // Hold one sticky bit, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= stat_d[i];
        end
    end
endmodule

// File: rtl/dbgq_req.sv
// Registered debug interrupt request generation.
// Assumes stat_d is the status value that takes effect at this edge.
module dbgq_req #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_d,
    input  logic         mode_int,
    input  logic         msr_de,
    output logic         req_q
);
    // Request only in internal mode with debug-enable set and a pending event.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= mode_int & msr_de & (|stat_d);
    end
endmodule

// File: rtl/dbgq_unit.sv
// Top of the debug event qualification unit.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module dbgq_unit
    import dbgq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_branch,
    input  logic            ev_trap,
    input  logic            ev_ret,
    input  logic [1:0]      ret_kind,
    input  logic            ev_done,
    input  logic            ev_irq,
    input  logic            irq_critical,
    input  logic            ev_ude,
    input  logic [EN_N-1:0] en,
    input  logic            msr_de,
    input  logic            mode_int,
    input  logic            mode_ext,
    input  logic            mode_wait,
    input  logic            clr_wr,
    input  logic [EV_N-1:0] clr_mask,
    output logic [EV_N-1:0] status,
    output logic            dbg_irq
);
    logic [EV_N-1:0] qual;
    logic [EV_N-1:0] stat_d;

    dbgq_gate u_gate (
        .ev_branch    (ev_branch),
        .ev_trap      (ev_trap),
        .ev_ret       (ev_ret),
        .ret_kind     (ret_kind),
        .ev_done      (ev_done),
        .ev_irq       (ev_irq),
        .irq_critical (irq_critical),
        .ev_ude       (ev_ude),
        .en           (en),
        .msr_de       (msr_de),
        .mode_int     (mode_int),
        .mode_ext     (mode_ext),
        .mode_wait    (mode_wait),
        .qual         (qual)
    );

    dbgq_status #(.W(EV_N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (qual),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .stat_q   (status),
        .stat_d   (stat_d)
    );

    dbgq_req #(.W(EV_N)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_d   (stat_d),
        .mode_int (mode_int),
        .msr_de   (msr_de),
        .req_q    (dbg_irq)
    );
endmodule

// File: rtl/dbgq_checker.sv
// Port-level properties of dbgq_unit, attached through bind.
// Assumes inputs are stable across each sampling edge.
module dbgq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_trap,
    input logic       ev_irq,
    input logic       irq_critical,
    input logic       ev_ude,
    input logic [4:0] en,
    input logic       msr_de,
    input logic       mode_int,
    input logic       mode_ext,
    input logic       mode_wait,
    input logic       clr_wr,
    input logic [5:0] clr_mask,
    input logic [5:0] status,
    input logic       dbg_irq
);
    // Enabled trap always lands in status.
    assert_trap_logged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_trap && en[1]) |=> status[1]);

    // Unconditional request always lands in status.
    assert_ude_logged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ude |=> status[5]);

    // Critical interrupt is blocked in plain internal mode.
    assert_crit_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_irq && irq_critical && mode_int && !mode_ext && !mode_wait && !status[4])
        |=> !status[4]);

    // Request only follows a cycle with internal mode and debug-enable set.
    assert_req_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> $past(mode_int && msr_de));

    // Request implies a recorded event.
    assert_req_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> (status != 6'd0));

    // Clearing the unconditional bit with no new request empties it.
    assert_clear_ude_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[5] && !ev_ude) |=> !status[5]);

    // Reset empties everything.
    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (status == 6'd0 && !dbg_irq));
endmodule

bind dbgq_unit dbgq_checker u_dbgq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_trap      (ev_trap),
    .ev_irq       (ev_irq),
    .irq_critical (irq_critical),
    .ev_ude       (ev_ude),
    .en           (en),
    .msr_de       (msr_de),
    .mode_int     (mode_int),
    .mode_ext     (mode_ext),
    .mode_wait    (mode_wait),
    .clr_wr       (clr_wr),
    .clr_mask     (clr_mask),
    .status       (status),
    .dbg_irq      (dbg_irq)
);

// File: tb/test_dbgq_unit.sv
// Directed bench for dbgq_unit: one task per scenario, each checking itself.
module test_dbgq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_branch = 0, ev_trap = 0, ev_ret = 0, ev_done = 0;
    logic       ev_irq = 0, irq_critical = 0, ev_ude = 0;
    logic [1:0] ret_kind = 2'b00;
    logic [4:0] en = '0;
    logic       msr_de = 0, mode_int = 0, mode_ext = 0, mode_wait = 0;
    logic       clr_wr = 0;
    logic [5:0] clr_mask = '0;
    logic [5:0] status;
    logic       dbg_irq;
    int         n_chk = 0;
    int         n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbgq_unit i_dbgq_unit (
        .clk(clk), .rst_n(rst_n), .ev_branch(ev_branch), .ev_trap(ev_trap),
        .ev_ret(ev_ret), .ret_kind(ret_kind), .ev_done(ev_done), .ev_irq(ev_irq),
        .irq_critical(irq_critical), .ev_ude(ev_ude), .en(en), .msr_de(msr_de),
        .mode_int(mode_int), .mode_ext(mode_ext), .mode_wait(mode_wait),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status), .dbg_irq(dbg_irq)
    );

    task automatic chk_stat(input logic [5:0] exp, input string tag);
        n_chk++;
        if (status !== exp) begin
            n_err++;
            $display("FAIL %s status act=%b exp=%b", tag, status, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (dbg_irq !== exp) begin
            n_err++;
            $display("FAIL %s dbg_irq act=%b exp=%b", tag, dbg_irq, exp);
        end
    endtask

    task automatic set_modes(input logic i, input logic e, input logic w, input logic de);
        mode_int = i; mode_ext = e; mode_wait = w; msr_de = de;
    endtask

    // Pulse strobes for one cycle; bits: 0 br,1 trap,2 ret,3 done,4 irq,5 ude.
    task automatic fire(input logic [5:0] ev, input logic crit, input logic [1:0] rk);
        ev_branch = ev[0]; ev_trap = ev[1]; ev_ret = ev[2];
        ev_done = ev[3]; ev_irq = ev[4]; ev_ude = ev[5];
        irq_critical = crit; ret_kind = rk;
        @(posedge clk); #1;
        {ev_branch, ev_trap, ev_ret, ev_done, ev_irq, ev_ude} = '0;
        irq_critical = 0; ret_kind = 2'b00;
    endtask

    task automatic clear_all();
        clr_wr = 1; clr_mask = 6'h3f;
        @(posedge clk); #1;
        clr_wr = 0; clr_mask = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        chk_stat(6'h00, "R12 reset");
        chk_irq(1'b0, "R12 reset");
        rst_n = 1;
    endtask

    task automatic t_branch();
        en = 5'h1f;
        set_modes(1, 0, 0, 0); fire(6'h01, 0, 0); chk_stat(6'h00, "R1 suppressed");
        set_modes(1, 1, 0, 0); fire(6'h01, 0, 0); chk_stat(6'h01, "R1 ext overrides");
        clear_all();
        en = 5'h1e; set_modes(0, 0, 0, 0); fire(6'h01, 0, 0); chk_stat(6'h00, "R1 disabled");
        en = 5'h1f; fire(6'h01, 0, 0); chk_stat(6'h01, "R1 no internal");
        clear_all();
    endtask

    task automatic t_trap();
        set_modes(1, 0, 0, 0); fire(6'h02, 0, 0); chk_stat(6'h02, "R2 trap ungated");
        clear_all();
    endtask

    task automatic t_ret();
        set_modes(1, 0, 0, 0);
        fire(6'h04, 0, 2'b00); chk_stat(6'h04, "R3 normal return");
        clear_all();
        fire(6'h04, 0, 2'b01); chk_stat(6'h00, "R4 critical return suppressed");
        fire(6'h04, 0, 2'b10); chk_stat(6'h00, "R4 mcheck return suppressed");
        set_modes(1, 0, 1, 0);
        fire(6'h04, 0, 2'b10); chk_stat(6'h04, "R4 wait overrides");
        clear_all();
        set_modes(1, 0, 0, 1);
        fire(6'h04, 0, 2'b01); chk_stat(6'h04, "R4 de set");
        clear_all();
    endtask

    task automatic t_done();
        set_modes(1, 0, 0, 0); fire(6'h08, 0, 0); chk_stat(6'h00, "R5 suppressed");
        set_modes(1, 0, 0, 1); fire(6'h08, 0, 0); chk_stat(6'h08, "R5 de set");
        clear_all();
    endtask

    task automatic t_irq();
        set_modes(1, 0, 0, 0); fire(6'h10, 0, 0); chk_stat(6'h10, "R6 noncritical");
        clear_all();
        set_modes(1, 0, 0, 1); fire(6'h10, 1, 0); chk_stat(6'h00, "R7 critical blocked de=1");
        set_modes(1, 1, 0, 0); fire(6'h10, 1, 0); chk_stat(6'h10, "R7 ext overrides");
        clear_all();
        set_modes(0, 0, 0, 0); fire(6'h10, 1, 0); chk_stat(6'h10, "R7 no internal");
        clear_all();
    endtask

    task automatic t_ude();
        en = '0; set_modes(1, 0, 0, 0);
        fire(6'h20, 0, 0); chk_stat(6'h20, "R8 unconditional");
        en = 5'h1f; clear_all();
    endtask

    task automatic t_req();
        set_modes(1, 0, 0, 1);
        chk_irq(1'b0, "R9 idle");
        fire(6'h02, 0, 0); chk_irq(1'b1, "R9 raised next edge");
        set_modes(0, 1, 1, 1);
        @(posedge clk); #1; chk_irq(1'b0, "R9 needs internal");
        set_modes(1, 0, 0, 0);
        @(posedge clk); #1; chk_irq(1'b0, "R9 needs de");
        clear_all(); set_modes(1, 0, 0, 1);
        @(posedge clk); #1; chk_irq(1'b0, "R9 empty status");
    endtask

    task automatic t_multi_clear();
        set_modes(0, 0, 0, 0);
        fire(6'h3f, 0, 2'b01); chk_stat(6'h3f, "R11 all at once");
        clr_wr = 1; clr_mask = 6'h05;
        @(posedge clk); #1; clr_wr = 0; clr_mask = '0;
        chk_stat(6'h3a, "R10 partial clear");
        clr_wr = 1; clr_mask = 6'h3a; ev_trap = 1;
        @(posedge clk); #1; clr_wr = 0; clr_mask = '0; ev_trap = 0;
        chk_stat(6'h02, "R10 set wins over clear");
        rst_n = 0; @(posedge clk); #1; rst_n = 1;
        chk_stat(6'h00, "R12 mid-run reset");
    endtask

    initial begin
        #1;
        t_reset();
        t_branch();
        t_trap();
        t_ret();
        t_done();
        t_irq();
        t_ude();
        t_req();
        t_multi_clear();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule